// File: doc/BRIEF.md
# Parameter-Set Link Reload Engine

This block holds the parameter memory of a DMA channel controller: a number of parameter sets, each made of eight 32-bit words. When a channel has submitted every transfer that its active set describes, the controller sends a completion request naming that set. The engine then refills the set from another set that a 16-bit link pointer inside it selects. This gives ping-pong buffering, circular transfers and chained lists without help from the processor.

A request first reads the options word and the link word of the active set. A set whose static bit is 1 is left alone. The link value FFFFh loads a null set, and a link that does not resolve to a set ends the request with an error flag. Any other link copies the eight words of the selected set into the active set. All eight source words are captured into a holding buffer before the first write, so a set linked to itself ends up with the same contents.

A table of queue-triggered channels maps each channel to one set and to one trigger word. When a reload writes that word into that set, the channel's event bit is set, which lets one queue channel walk a linked list of sets by itself. A host port writes the memory before use and reads it back.

Top module: `plink_engine`

## Requirements
- R1: A completion request for a set whose word 0 bit 3 is 0, and whose link field (word 5, bits 15:0) selects another set, copies all eight words of the selected set into the requesting set, word for word. The selected set is not modified.
- R2: When word 0 bit 3 of the requesting set is 1, no word of any set changes, whatever the link field holds.
- R3: A link field of FFFFh reads no set. Words 0-4, 6 and 7 of the requesting set become 0, and word 5 becomes 0000FFFFh.
- R4: The link field is a byte address. The index of the selected set is (link - LINK_BASE) >> 5, with LINK_BASE = 4000h by default, and link bits 4:0 have no effect on the choice.
- R5: A link below LINK_BASE, or one whose index is 256 or more, changes no word. The request finishes with link_err high in the same cycle as done.
- R6: A set whose link selects itself keeps all eight words unchanged after the reload.
- R7: Take the request as sampled at clock edge E0. busy is 1 from E0 until done falls. done is a one-cycle pulse following edge E17 for a copy, E9 for a null load, and E1 for a static or failed request.
- R8: A request that arrives while busy is held in a one-deep slot and starts at the edge that ends done, so its done follows 18 cycles after the first one. A request that arrives while the slot is full is dropped.
- R9: Queue channel i (qmap_en[i] = 1, set qmap_set[8i+7:8i], word qmap_word[3i+2:3i]) gets qevt[i] = 1 at the edge that writes that word of that set during a reload. This is edge E10+w for a copy and E2+w for a null load. The bit holds until qevt_clr[i] is 1 at a clock edge. Static and failed requests raise no event.
- R10: The host write port writes word host_waddr = set*8 + word at a clock edge when busy is 0, and is ignored while busy is 1. host_rdata returns the word at host_raddr one clock edge after the address is applied.
- R11: After reset, busy, done, link_err, qevt and host_rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 11 | Host write word address (set*8 + word) |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 11 | Host read word address |
| host_rdata | output | 32 | Host read data, one cycle after the address |
| cmp_valid | input | 1 | Completion request strobe |
| cmp_set | input | 8 | Index of the exhausted active set |
| qmap_en | input | 8 | Queue channel enables |
| qmap_set | input | 64 | Set index per queue channel, 8 bits each |
| qmap_word | input | 24 | Trigger word per queue channel, 3 bits each |
| qevt_clr | input | 8 | Clears queue event bits |
| busy | output | 1 | Reload sequence in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| link_err | output | 1 | Request ended on an unresolvable link |
| qevt | output | 8 | Sticky queue trigger events |

## Verification
A wrong decision in the header cycle shows up at once as a done pulse at the wrong cycle: 2, 10 or 18 cycles after acceptance. The bench therefore counts cycles for every request. A bad word counter, buffer slot or address shows up as a wrong word in the reloaded set. Reading back all eight words finds it within a few cycles of done. A trigger-word or channel-match error moves or hides the qevt rise, and the bench pins that rise to the exact cycle. A corrupt pending slot shows up as a missing, late or extra second done pulse.

// File: rtl/plink_pkg.sv
package plink_pkg;

  typedef enum logic [2:0] {
    PLK_IDLE  = 3'd0,
    PLK_HDR   = 3'd1,
    PLK_READ  = 3'd2,
    PLK_WRITE = 3'd3,
    PLK_DONE  = 3'd4
  } plk_state_e;

  localparam logic [15:0] PLK_NULL_LINK = 16'hFFFF;

endpackage

// File: rtl/plink_ram.sv
module plink_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [ADDR_W-1:0] rda_addr,
  output logic [DATA_W-1:0] rda_data,
  input  logic [ADDR_W-1:0] rdb_addr,
  output logic [DATA_W-1:0] rdb_data,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_waddr,
  input  logic [DATA_W-1:0] eng_wdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              host_wr_en;
  logic [DATA_W-1:0] host_rdata_d;

  assign host_wr_en   = host_we && !busy;
  assign rda_data     = mem[rda_addr];
  assign rdb_data     = mem[rdb_addr];
  assign host_rdata_d = mem[host_raddr];

  always_ff @(posedge clk) begin
    if (eng_we) begin
      mem[eng_waddr] <= eng_wdata;
    end else if (host_wr_en) begin
      mem[host_waddr] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else begin
      host_rdata <= host_rdata_d;
    end
  end

  assert_engine_write_busy_R10: assert property (
    @(posedge clk) disable iff (!rst_n) eng_we |-> busy
  );

endmodule

// File: rtl/plink_seq.sv
module plink_seq
  import plink_pkg::*;
#(
  parameter int          NUM_SETS   = 256,
  parameter int          SET_WORDS  = 8,
  parameter int          DATA_W     = 32,
  parameter logic [15:0] LINK_BASE  = 16'h4000,
  parameter int          STATIC_BIT = 3,
  parameter int          LINK_WORD  = 5,
  parameter int          SET_W      = $clog2(NUM_SETS),
  parameter int          WORD_W     = $clog2(SET_WORDS),
  parameter int          ADDR_W     = SET_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [SET_W-1:0]  cmp_set,
  output logic [ADDR_W-1:0] rda_addr,
  input  logic [DATA_W-1:0] rda_data,
  output logic [ADDR_W-1:0] rdb_addr,
  input  logic [DATA_W-1:0] rdb_data,
  output logic              eng_we,
  output logic [ADDR_W-1:0] eng_waddr,
  output logic [DATA_W-1:0] eng_wdata,
  output logic [SET_W-1:0]  act_set,
  output logic [WORD_W-1:0] act_word,
  output logic              busy,
  output logic              done,
  output logic              link_err
);

  localparam int SHIFT = $clog2(SET_WORDS * DATA_W / 8);
  localparam int IDX_W = 16 - SHIFT;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(SET_WORDS - 1);
  localparam logic [WORD_W-1:0] LINK_SLOT = WORD_W'(LINK_WORD);
  localparam logic [DATA_W-1:0] NULL_LINK_WORD = {{(DATA_W-16){1'b0}}, PLK_NULL_LINK};

  plk_state_e        state_q, state_d;
  logic [WORD_W-1:0] cnt_q, cnt_d;
  logic [SET_W-1:0]  act_q, act_d;
  logic [SET_W-1:0]  src_q, src_d;
  logic              err_q, err_d;
  logic              pend_vld_q, pend_vld_d;
  logic [SET_W-1:0]  pend_set_q, pend_set_d;
  logic [DATA_W-1:0] hold_q [SET_WORDS];
  logic              hold_ld, hold_null;

  logic              hdr_static;
  logic [15:0]       hdr_link;
  logic [16:0]       link_diff;
  logic [IDX_W-1:0]  link_idx;
  logic              link_null, link_bad;

  assign hdr_static = rda_data[STATIC_BIT];
  assign hdr_link   = rdb_data[15:0];
  assign link_diff  = {1'b0, hdr_link} - {1'b0, LINK_BASE};
  assign link_idx   = link_diff[15:SHIFT];
  assign link_null  = (hdr_link == PLK_NULL_LINK);
  assign link_bad   = !link_null &&
                      (link_diff[16] || (32'(link_idx) >= 32'(NUM_SETS)));

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    act_d      = act_q;
    src_d      = src_q;
    err_d      = err_q;
    pend_vld_d = pend_vld_q;
    pend_set_d = pend_set_q;
    hold_ld    = 1'b0;
    hold_null  = 1'b0;
    eng_we     = 1'b0;
    rda_addr   = {act_q, {WORD_W{1'b0}}};
    rdb_addr   = {act_q, LINK_SLOT};

    if ((state_q == PLK_HDR || state_q == PLK_READ || state_q == PLK_WRITE) &&
        cmp_valid && !pend_vld_q) begin
      pend_vld_d = 1'b1;
      pend_set_d = cmp_set;
    end

    case (state_q)
      PLK_IDLE: begin
        if (cmp_valid) begin
          act_d   = cmp_set;
          state_d = PLK_HDR;
        end
      end
      PLK_HDR: begin
        err_d = 1'b0;
        cnt_d = '0;
        if (hdr_static) begin
          state_d = PLK_DONE;
        end else if (link_null) begin
          hold_null = 1'b1;
          state_d   = PLK_WRITE;
        end else if (link_bad) begin
          err_d   = 1'b1;
          state_d = PLK_DONE;
        end else begin
          src_d   = link_idx[SET_W-1:0];
          state_d = PLK_READ;
        end
      end
      PLK_READ: begin
        rda_addr = {src_q, cnt_q};
        hold_ld  = 1'b1;
        if (cnt_q == LAST_WORD) begin
          cnt_d   = '0;
          state_d = PLK_WRITE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PLK_WRITE: begin
        eng_we = 1'b1;
        if (cnt_q == LAST_WORD) begin
          cnt_d   = '0;
          state_d = PLK_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PLK_DONE: begin
        if (pend_vld_q) begin
          act_d      = pend_set_q;
          pend_vld_d = 1'b0;
          state_d    = PLK_HDR;
        end else if (cmp_valid) begin
          act_d   = cmp_set;
          state_d = PLK_HDR;
        end else begin
          state_d = PLK_IDLE;
        end
      end
      default: state_d = PLK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PLK_IDLE;
      cnt_q      <= '0;
      act_q      <= '0;
      src_q      <= '0;
      err_q      <= 1'b0;
      pend_vld_q <= 1'b0;
      pend_set_q <= '0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      act_q      <= act_d;
      src_q      <= src_d;
      err_q      <= err_d;
      pend_vld_q <= pend_vld_d;
      pend_set_q <= pend_set_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_null) begin
      for (int w = 0; w < SET_WORDS; w++) begin
        hold_q[w] <= (w == LINK_WORD) ? NULL_LINK_WORD : '0;
      end
    end else if (hold_ld) begin
      hold_q[cnt_q] <= rda_data;
    end
  end

  assign eng_waddr = {act_q, cnt_q};
  assign eng_wdata = hold_q[cnt_q];
  assign act_set   = act_q;
  assign act_word  = cnt_q;
  assign busy      = (state_q != PLK_IDLE);
  assign done      = (state_q == PLK_DONE);
  assign link_err  = done && err_q;

  assert_done_single_R7: assert property (
    @(posedge clk) disable iff (!rst_n) done |=> !done
  );

  assert_write_run_end_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
      (state_q == PLK_WRITE && cnt_q == LAST_WORD) |=> done
  );

  assert_static_skip_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
      (state_q == PLK_HDR && hdr_static) |=> (done && !eng_we)
  );

  assert_bad_link_done_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
      (state_q == PLK_HDR && !hdr_static && link_bad) |=> link_err
  );

  assert_pend_served_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
      (done && pend_vld_q) |=> (state_q == PLK_HDR && act_q == $past(pend_set_q))
  );

endmodule

// File: rtl/plink_qtrig.sv
module plink_qtrig #(
  parameter int NUM_QCH = 8,
  parameter int SET_W   = 8,
  parameter int WORD_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SET_W-1:0]         wr_set,
  input  logic [WORD_W-1:0]        wr_word,
  input  logic [NUM_QCH-1:0]       qmap_en,
  input  logic [NUM_QCH*SET_W-1:0] qmap_set,
  input  logic [NUM_QCH*WORD_W-1:0] qmap_word,
  input  logic [NUM_QCH-1:0]       qevt_clr,
  output logic [NUM_QCH-1:0]       qevt
);

  logic [NUM_QCH-1:0] hit;
  logic [NUM_QCH-1:0] qevt_d;

  for (genvar ch = 0; ch < NUM_QCH; ch++) begin : g_ch
    assign hit[ch] = wr_en && qmap_en[ch] &&
                     (qmap_set[ch*SET_W +: SET_W] == wr_set) &&
                     (qmap_word[ch*WORD_W +: WORD_W] == wr_word);

    assign qevt_d[ch] = hit[ch] || (qevt[ch] && !qevt_clr[ch]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        qevt[ch] <= 1'b0;
      end else begin
        qevt[ch] <= qevt_d[ch];
      end
    end

    assert_qevt_cause_R9: assert property (
      @(posedge clk) disable iff (!rst_n)
        $rose(qevt[ch]) |-> $past(wr_en && qmap_en[ch])
    );
  end

endmodule

// File: rtl/plink_engine.sv
module plink_engine #(
  parameter int          NUM_SETS   = 256,
  parameter int          SET_WORDS  = 8,
  parameter int          DATA_W     = 32,
  parameter int          NUM_QCH    = 8,
  parameter logic [15:0] LINK_BASE  = 16'h4000,
  parameter int          STATIC_BIT = 3,
  parameter int          LINK_WORD  = 5,
  parameter int          SET_W      = $clog2(NUM_SETS),
  parameter int          WORD_W     = $clog2(SET_WORDS),
  parameter int          ADDR_W     = SET_W + WORD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_we,
  input  logic [ADDR_W-1:0]         host_waddr,
  input  logic [DATA_W-1:0]         host_wdata,
  input  logic [ADDR_W-1:0]         host_raddr,
  output logic [DATA_W-1:0]         host_rdata,
  input  logic                      cmp_valid,
  input  logic [SET_W-1:0]          cmp_set,
  input  logic [NUM_QCH-1:0]        qmap_en,
  input  logic [NUM_QCH*SET_W-1:0]  qmap_set,
  input  logic [NUM_QCH*WORD_W-1:0] qmap_word,
  input  logic [NUM_QCH-1:0]        qevt_clr,
  output logic                      busy,
  output logic                      done,
  output logic                      link_err,
  output logic [NUM_QCH-1:0]        qevt
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] rda_addr, rdb_addr, eng_waddr;
  logic [DATA_W-1:0] rda_data, rdb_data, eng_wdata;
  logic              eng_we;
  logic [SET_W-1:0]  act_set;
  logic [WORD_W-1:0] act_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  plink_ram #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ram (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .busy       (busy),
    .host_we    (host_we),
    .host_waddr (host_waddr),
    .host_wdata (host_wdata),
    .host_raddr (host_raddr),
    .host_rdata (host_rdata),
    .rda_addr   (rda_addr),
    .rda_data   (rda_data),
    .rdb_addr   (rdb_addr),
    .rdb_data   (rdb_data),
    .eng_we     (eng_we),
    .eng_waddr  (eng_waddr),
    .eng_wdata  (eng_wdata)
  );

  plink_seq #(
    .NUM_SETS   (NUM_SETS),
    .SET_WORDS  (SET_WORDS),
    .DATA_W     (DATA_W),
    .LINK_BASE  (LINK_BASE),
    .STATIC_BIT (STATIC_BIT),
    .LINK_WORD  (LINK_WORD),
    .SET_W      (SET_W),
    .WORD_W     (WORD_W),
    .ADDR_W     (ADDR_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmp_valid (cmp_valid),
    .cmp_set   (cmp_set),
    .rda_addr  (rda_addr),
    .rda_data  (rda_data),
    .rdb_addr  (rdb_addr),
    .rdb_data  (rdb_data),
    .eng_we    (eng_we),
    .eng_waddr (eng_waddr),
    .eng_wdata (eng_wdata),
    .act_set   (act_set),
    .act_word  (act_word),
    .busy      (busy),
    .done      (done),
    .link_err  (link_err)
  );

  plink_qtrig #(
    .NUM_QCH (NUM_QCH),
    .SET_W   (SET_W),
    .WORD_W  (WORD_W)
  ) u_qtrig (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (eng_we),
    .wr_set    (act_set),
    .wr_word   (act_word),
    .qmap_en   (qmap_en),
    .qmap_set  (qmap_set),
    .qmap_word (qmap_word),
    .qevt_clr  (qevt_clr),
    .qevt      (qevt)
  );

endmodule

// File: tb/plink_engine_test.sv
module plink_engine_test;

  localparam int K_COPY = 0, K_STAT = 1, K_NULL = 2, K_ERR = 3, K_SELF = 4;
  localparam int NV = 9;
  // {kind[2:0], static, dst[7:0], link[15:0]}
  localparam logic [27:0] VEC [NV] = '{
    {3'd0, 1'b0, 8'd3,   16'h4140},
    {3'd0, 1'b0, 8'd200, 16'h5FE7},
    {3'd0, 1'b0, 8'd0,   16'h4020},
    {3'd1, 1'b1, 8'd5,   16'h4140},
    {3'd2, 1'b0, 8'd7,   16'hFFFF},
    {3'd1, 1'b1, 8'd8,   16'hFFFF},
    {3'd3, 1'b0, 8'd9,   16'h3FE0},
    {3'd3, 1'b0, 8'd11,  16'h6000},
    {3'd4, 1'b0, 8'd12,  16'h4180}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [10:0] host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [10:0] host_raddr = '0;
  logic [31:0] host_rdata;
  logic        cmp_valid = 1'b0;
  logic [7:0]  cmp_set = '0;
  logic [7:0]  qmap_en = '0;
  logic [63:0] qmap_set = '0;
  logic [23:0] qmap_word = '0;
  logic [7:0]  qevt_clr = '0;
  logic        busy, done, link_err;
  logic [7:0]  qevt;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  plink_engine uut (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .cmp_valid(cmp_valid), .cmp_set(cmp_set),
    .qmap_en(qmap_en), .qmap_set(qmap_set), .qmap_word(qmap_word),
    .qevt_clr(qevt_clr),
    .busy(busy), .done(done), .link_err(link_err), .qevt(qevt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int s, input int w);
    return {s[7:0], 5'b0, w[2:0], 16'hC352};
  endfunction

  function automatic logic [31:0] dst_word(input int s, input int w,
                                          input logic st, input logic [15:0] lk);
    if (w == 0) return pat(s, 0) | {28'd0, st, 3'd0};
    if (w == 5) return {16'h9A00, lk};
    return pat(s, w);
  endfunction

  task automatic hwrite(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = 11'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input int a, output logic [31:0] d);
    @(negedge clk);
    host_raddr = 11'(a);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic fill_dst(input int s, input logic st, input logic [15:0] lk);
    for (int w = 0; w < 8; w++) hwrite(s * 8 + w, dst_word(s, w, st, lk));
  endtask

  task automatic fill_src(input int s);
    for (int w = 0; w < 8; w++) hwrite(s * 8 + w, pat(s, w));
  endtask

  // returns the negedge index at which done was seen and at which qevt first went nonzero
  task automatic fire(input int s, output int c, output logic e, output int tq);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_set = 8'(s);
    @(negedge clk);
    cmp_valid = 1'b0;
    c = 1; tq = 0;
    chk("R7 busy after accept", {31'd0, busy}, 32'd1);
    while (!done && c < 100) begin
      @(negedge clk);
      c++;
      if (qevt != 0 && tq == 0) tq = c;
    end
    e = link_err;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c, tq, src, kind, dst;
    logic e, st;
    logic [15:0] lk;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 busy", {31'd0, busy}, 32'd0);
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 link_err", {31'd0, link_err}, 32'd0);
    chk("R11 qevt", {24'd0, qevt}, 32'd0);
    chk("R11 host_rdata", host_rdata, 32'd0);

    // R10 host port round trip
    hwrite(100, 32'hDEAD_0064);
    hread(100, d);
    chk("R10 host readback", d, 32'hDEAD_0064);

    // vector table
    for (int i = 0; i < NV; i++) begin
      kind = int'(VEC[i][27:25]);
      st   = VEC[i][24];
      dst  = int'(VEC[i][23:16]);
      lk   = VEC[i][15:0];
      src  = int'((lk - 16'h4000) >> 5);
      fill_dst(dst, st, lk);
      if (kind == K_COPY) fill_src(src);
      fire(dst, c, e, tq);
      chk("R7 done cycle", c,
          (kind == K_COPY || kind == K_SELF) ? 32'd18 : (kind == K_NULL ? 32'd10 : 32'd2));
      chk("R5 link_err", {31'd0, e}, (kind == K_ERR) ? 32'd1 : 32'd0);
      for (int w = 0; w < 8; w++) begin
        hread(dst * 8 + w, d);
        case (kind)
          K_COPY: chk("R1/R4 copied word", d, pat(src, w));
          K_NULL: chk("R3 null word", d, (w == 5) ? 32'h0000_FFFF : 32'd0);
          K_STAT: chk("R2 static unchanged", d, dst_word(dst, w, st, lk));
          K_ERR:  chk("R5 bad link unchanged", d, dst_word(dst, w, st, lk));
          default: chk("R6 self link", d, dst_word(dst, w, st, lk));
        endcase
      end
      if (kind == K_COPY) begin
        hread(src * 8 + 5, d);
        chk("R1 source intact", d, pat(src, 5));
      end
    end

    // R8 pending and R10 host write while busy
    begin
      int n1, n2, nd;
      fill_dst(50, 1'b0, 16'h4780); fill_src(60);
      fill_dst(51, 1'b0, 16'h47A0); fill_src(61);
      fill_dst(52, 1'b0, 16'h47C0); fill_src(62);
      hwrite(241, 32'h1111_0000);
      @(negedge clk);
      cmp_valid = 1'b1; cmp_set = 8'd50;
      n1 = 0; n2 = 0; nd = 0;
      for (int n = 1; n <= 40; n++) begin
        @(negedge clk);
        if (done) begin
          nd++;
          if (n1 == 0) n1 = n; else n2 = n;
        end
        case (n)
          1: cmp_valid = 1'b0;
          3: begin cmp_valid = 1'b1; cmp_set = 8'd51; end
          4: cmp_set = 8'd52;
          5: cmp_valid = 1'b0;
          6: begin host_we = 1'b1; host_waddr = 11'd241; host_wdata = 32'h2222_0000; end
          7: host_we = 1'b0;
          default: ;
        endcase
      end
      chk("R8 first done", n1, 18);
      chk("R8 held request done", n2, 36);
      chk("R8 done count", nd, 2);
      hread(51 * 8 + 3, d);
      chk("R8 held request copied", d, pat(61, 3));
      hread(52 * 8 + 1, d);
      chk("R8 dropped request no effect", d, dst_word(52, 1, 1'b0, 16'h47C0));
      hread(241, d);
      chk("R10 host write ignored while busy", d, 32'h1111_0000);
    end

    // R9 queue trigger events
    qmap_en = 8'b0010_0100;
    qmap_set[2*8 +: 8] = 8'd20; qmap_word[2*3 +: 3] = 3'd6;
    qmap_set[3*8 +: 8] = 8'd20; qmap_word[3*3 +: 3] = 3'd6;
    qmap_set[5*8 +: 8] = 8'd21; qmap_word[5*3 +: 3] = 3'd0;
    fill_dst(20, 1'b0, 16'h4500); fill_src(40);
    fire(20, c, e, tq);
    chk("R9 copy trigger cycle", tq, 17);
    chk("R9 only mapped enabled channel", {24'd0, qevt}, 32'h04);
    @(negedge clk);
    chk("R9 event sticky", {24'd0, qevt}, 32'h04);
    qevt_clr = 8'h04;
    @(negedge clk);
    qevt_clr = 8'h00;
    chk("R9 event cleared", {24'd0, qevt}, 32'h00);
    fill_dst(21, 1'b1, 16'hFFFF);
    fire(21, c, e, tq);
    chk("R9 static gives no event", {24'd0, qevt}, 32'h00);
    fill_dst(21, 1'b0, 16'hFFFF);
    fire(21, c, e, tq);
    chk("R9 null trigger cycle", tq, 3);
    chk("R9 null event channel", {24'd0, qevt}, 32'h20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule